// File: doc/BRIEF.md
# Shadow-Masked Dual-Context Interrupt Controller

This block gathers 40 level-sensitive interrupt lines and presents them to two hardware thread contexts. Each context gets a registered request flag and a registered vector number naming the highest-numbered source that is active and enabled for it. Software programs enable bits through a small 32-bit register port. That port takes a plain read, or a write that carries a per-bit enable mask, so one access performs a read-modify-write of an enable word. The raw state of the lines can also be read back.

Most sources reach exactly one context, selected by a build-time routing vector. Some sources are per-CPU and must be able to reach both contexts under independent control. For each of these, a spare source number is paired with it at build time as its shadow. The source's own enable bit gates delivery to context 0, and the shadow number's enable bit gates delivery of the same source to context 1. A shadow number is never an interrupt in its own right: its line is ignored for both pending status and delivery.

The register port runs a two-state machine. PORT_IDLE moves to PORT_RESP on an accepted request (transition ACCEPT). PORT_RESP stays in PORT_RESP on a back-to-back request (transition CHAIN) and returns to PORT_IDLE when no request is present (transition DRAIN). A response is valid exactly while the machine is in PORT_RESP.

Top module: `shmic_top`

## Requirements
- R1: After reset every enable bit is 0, both request flags are low and both vectors read 0. Writing 0 with a full bit mask to both enable words returns the outputs to that quiet state.
- R2: Enable bits for sources 0 to 31 sit in bits 0 to 31 of the word at offset 0x04. Enable bits for sources 32 to 39 sit in bits 0 to 7 of the word at offset 0x50.
- R3: A write stores (old AND NOT bmask) OR (wdata AND bmask) into the addressed enable word. A request in cycle N gives rsp_valid in cycle N+1. A read returns its data with that response, and a write returns zero data.
- R4: Offset 0x08 returns the raw line state for sources 0 to 31, and offset 0x54 returns lines 32 to 39 in bits 0 to 7. Enable bits do not affect either value.
- R5: A source used as a shadow never reads as pending and never produces a request or a vector in either context, even while its line is high and its enable bit is 1.
- R6: A source that is not per-CPU goes to context 1 when its bit in the routing vector is 1, and to context 0 otherwise. It never reaches both contexts.
- R7: For a per-CPU source, its own enable bit gates context 0 and its shadow's enable bit gates context 1, independently of each other.
- R8: Each context's vector is 1 plus the highest source number that is high and enabled for that context, or 0 if there is none. The request flag is high exactly when the vector is nonzero. Both are registered and reflect line and enable state one clock later.
- R9: A write to any offset other than the two enable words has no effect, and reads of unused offsets return 0. Bits 8 to 31 of the upper enable word are not stored and read as 0.
- R10: The pending words are read-only. A write to offset 0x08 or 0x54 changes no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lines | input | 40 | Level interrupt lines, one per source |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = masked write, 0 = read |
| req_addr | input | 8 | Byte offset of the accessed word |
| req_wdata | input | 32 | Write data |
| req_bmask | input | 32 | Per-bit write enable |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| ctx0_irq | output | 1 | Context 0 request |
| ctx0_vec | output | 6 | Context 0 vector (source + 1, 0 = none) |
| ctx1_irq | output | 1 | Context 1 request |
| ctx1_vec | output | 6 | Context 1 vector (source + 1, 0 = none) |

## Verification
The bench builds the block with its default configuration. Sources 30 and 35 are per-CPU, with shadows 29 and 12. Sources 24 to 27 and 38 are routed to context 1. Because source 12 shadows a source in the upper word, an enable bit in one word gates a source held in the other word, and the context 1 vector falls back across that word boundary as enables are cleared. Source 30 sits directly above its shadow, so an off-by-one in the pairing would show up. A behavioural model, which decides per source by searching the pair list, is compared with every output on every clock.

// File: rtl/shmic_pkg.sv
`timescale 1ns/1ps
package shmic_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_EN_LO   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_LVL_LO  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EN_HI   = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_LVL_HI  = 8'h54;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN_LO,
        SEL_EN_HI,
        SEL_LVL_LO,
        SEL_LVL_HI
    } reg_sel_t;

    typedef enum logic {
        PORT_IDLE,
        PORT_RESP
    } port_state_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_EN_LO:  return SEL_EN_LO;
            OFS_EN_HI:  return SEL_EN_HI;
            OFS_LVL_LO: return SEL_LVL_LO;
            OFS_LVL_HI: return SEL_LVL_HI;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/shmic_port.sv
`timescale 1ns/1ps
module shmic_port
    import shmic_pkg::*;
#(
    parameter int NUM_SRC = 40,
    localparam int HI_W = NUM_SRC - 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [NUM_SRC-1:0] en_q,
    input  logic [NUM_SRC-1:0] lvl,
    output logic               we_lo,
    output logic               we_hi,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata
);

    port_state_t state_q, state_d;
    reg_sel_t    sel;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;

    assign sel = decode_addr(req_addr);

    // next-state logic: ACCEPT, CHAIN, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: if (req_valid)  state_d = PORT_RESP;
            PORT_RESP: if (!req_valid) state_d = PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    // read word selection
    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_EN_LO:  rd_word = en_q[31:0];
            SEL_EN_HI:  rd_word = {{(DATA_W-HI_W){1'b0}}, en_q[NUM_SRC-1:32]};
            SEL_LVL_LO: rd_word = lvl[31:0];
            SEL_LVL_HI: rd_word = {{(DATA_W-HI_W){1'b0}}, lvl[NUM_SRC-1:32]};
            SEL_NONE:   rd_word = '0;
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= (req_valid && !req_write) ? rd_word : '0;
    end

    // outputs
    always_comb begin
        rsp_valid = (state_q == PORT_RESP);
        rsp_rdata = rdata_q;
        we_lo     = req_valid && req_write && (sel == SEL_EN_LO);
        we_hi     = req_valid && req_write && (sel == SEL_EN_HI);
    end

endmodule

// File: rtl/shmic_enable.sv
`timescale 1ns/1ps
module shmic_enable
    import shmic_pkg::*;
#(
    parameter int NUM_SRC = 40,
    localparam int HI_W = NUM_SRC - 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_lo,
    input  logic               we_hi,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  bmask,
    output logic [NUM_SRC-1:0] en_q
);

    logic [31:0]   lo_d;
    logic [HI_W-1:0] hi_d;

    always_comb begin
        lo_d = (en_q[31:0] & ~bmask) | (wdata & bmask);
        hi_d = (en_q[NUM_SRC-1:32] & ~bmask[HI_W-1:0]) | (wdata[HI_W-1:0] & bmask[HI_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            if (we_lo) en_q[31:0]         <= lo_d;
            if (we_hi) en_q[NUM_SRC-1:32] <= hi_d;
        end
    end

endmodule

// File: rtl/shmic_route.sv
`timescale 1ns/1ps
module shmic_route #(
    parameter int                   NUM_SRC   = 40,
    parameter logic [NUM_SRC-1:0]   SHADOW_SET = '0,
    parameter logic [NUM_SRC-1:0]   PERCPU_SET = '0,
    parameter logic [NUM_SRC*8-1:0] SHADOW_OF  = '0,
    parameter logic [NUM_SRC-1:0]   ROUTE1     = '0
) (
    input  logic [NUM_SRC-1:0] lines,
    input  logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] lvl,
    output logic [NUM_SRC-1:0] act0,
    output logic [NUM_SRC-1:0] act1
);

    // shadow numbers are masking slots only: their lines are dropped here
    assign lvl = lines & ~SHADOW_SET;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int SI = int'(SHADOW_OF[i*8 +: 8]);
        if (SHADOW_SET[i]) begin : g_shadow
            assign act0[i] = 1'b0;
            assign act1[i] = 1'b0;
        end else if (PERCPU_SET[i]) begin : g_percpu
            assign act0[i] = lvl[i] & en_q[i];
            assign act1[i] = lvl[i] & en_q[SI];
        end else if (ROUTE1[i]) begin : g_ctx1
            assign act0[i] = 1'b0;
            assign act1[i] = lvl[i] & en_q[i];
        end else begin : g_ctx0
            assign act0[i] = lvl[i] & en_q[i];
            assign act1[i] = 1'b0;
        end
    end

endmodule

// File: rtl/shmic_vec.sv
`timescale 1ns/1ps
module shmic_vec #(
    parameter int NUM_SRC = 40,
    localparam int VEC_W = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] act,
    output logic               irq_q,
    output logic [VEC_W-1:0]   vec_q
);

    logic [VEC_W-1:0] best;

    // ascending scan: the last hit is the highest-numbered source
    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act[i]) best = VEC_W'(i + 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= |act;
            vec_q <= best;
        end
    end

endmodule

// File: rtl/shmic_top.sv
`timescale 1ns/1ps
module shmic_top
    import shmic_pkg::*;
#(
    parameter int             NUM_SRC   = 40,
    parameter int             NUM_PAIRS = 2,
    parameter int             PAIR_TGT [NUM_PAIRS] = '{30, 35},
    parameter int             PAIR_SHD [NUM_PAIRS] = '{29, 12},
    parameter logic [NUM_SRC-1:0] ROUTE1 = 40'h40_0F00_0000,
    localparam int            VEC_W = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lines,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [DATA_W-1:0]  req_bmask,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               ctx0_irq,
    output logic [VEC_W-1:0]   ctx0_vec,
    output logic               ctx1_irq,
    output logic [VEC_W-1:0]   ctx1_vec
);

    function automatic logic [NUM_SRC-1:0] f_shadow_set();
        logic [NUM_SRC-1:0] s;
        s = '0;
        for (int p = 0; p < NUM_PAIRS; p++) s[PAIR_SHD[p]] = 1'b1;
        return s;
    endfunction

    function automatic logic [NUM_SRC-1:0] f_percpu_set();
        logic [NUM_SRC-1:0] s;
        s = '0;
        for (int p = 0; p < NUM_PAIRS; p++) s[PAIR_TGT[p]] = 1'b1;
        return s;
    endfunction

    function automatic logic [NUM_SRC*8-1:0] f_shadow_of();
        logic [NUM_SRC*8-1:0] m;
        for (int i = 0; i < NUM_SRC; i++) m[i*8 +: 8] = 8'(i);
        for (int p = 0; p < NUM_PAIRS; p++) m[PAIR_TGT[p]*8 +: 8] = 8'(PAIR_SHD[p]);
        return m;
    endfunction

    localparam logic [NUM_SRC-1:0]   SHADOW_SET = f_shadow_set();
    localparam logic [NUM_SRC-1:0]   PERCPU_SET = f_percpu_set();
    localparam logic [NUM_SRC*8-1:0] SHADOW_OF  = f_shadow_of();
    localparam int                   NUM_CTX    = 2;

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] lvl;
    logic               we_lo, we_hi;
    logic [NUM_CTX-1:0][NUM_SRC-1:0] act;
    logic [NUM_CTX-1:0]              irq_c;
    logic [NUM_CTX-1:0][VEC_W-1:0]   vec_c;

    shmic_port #(.NUM_SRC(NUM_SRC)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .en_q      (en_q),
        .lvl       (lvl),
        .we_lo     (we_lo),
        .we_hi     (we_hi),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    shmic_enable #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .we_lo (we_lo),
        .we_hi (we_hi),
        .wdata (req_wdata),
        .bmask (req_bmask),
        .en_q  (en_q)
    );

    shmic_route #(
        .NUM_SRC    (NUM_SRC),
        .SHADOW_SET (SHADOW_SET),
        .PERCPU_SET (PERCPU_SET),
        .SHADOW_OF  (SHADOW_OF),
        .ROUTE1     (ROUTE1)
    ) u_route (
        .lines (src_lines),
        .en_q  (en_q),
        .lvl   (lvl),
        .act0  (act[0]),
        .act1  (act[1])
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        shmic_vec #(.NUM_SRC(NUM_SRC)) u_vec (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (act[c]),
            .irq_q (irq_c[c]),
            .vec_q (vec_c[c])
        );
    end

    assign ctx0_irq = irq_c[0];
    assign ctx0_vec = vec_c[0];
    assign ctx1_irq = irq_c[1];
    assign ctx1_vec = vec_c[1];

endmodule

// File: rtl/shmic_checker.sv
`timescale 1ns/1ps
module shmic_checker #(
    parameter int                 NUM_SRC    = 40,
    parameter int                 VEC_W      = 6,
    parameter logic [NUM_SRC-1:0] SHADOW_SET = '0,
    parameter logic [NUM_SRC-1:0] PERCPU_SET = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [7:0]       req_addr,
    input logic             rsp_valid,
    input logic [31:0]      rsp_rdata,
    input logic             ctx0_irq,
    input logic [VEC_W-1:0] ctx0_vec,
    input logic             ctx1_irq,
    input logic [VEC_W-1:0] ctx1_vec
);

    localparam int HI_W = NUM_SRC - 32;

    logic rd_req, rd_unused, rd_hi, rd_lvl_lo;
    assign rd_req    = req_valid && !req_write;
    assign rd_unused = rd_req && !(req_addr == 8'h04 || req_addr == 8'h50 ||
                                   req_addr == 8'h08 || req_addr == 8'h54);
    assign rd_hi     = rd_req && (req_addr == 8'h50 || req_addr == 8'h54);
    assign rd_lvl_lo = rd_req && (req_addr == 8'h08);

    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!ctx0_irq && !ctx1_irq && ctx0_vec == '0 &&
                                      ctx1_vec == '0 && !rsp_valid);
        end
    end

    p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_write_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

    p_shadow_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lvl_lo |=> ((rsp_rdata & SHADOW_SET[31:0]) == '0));

    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctx0_vec == ctx1_vec) && (ctx0_vec != '0)) |-> PERCPU_SET[ctx0_vec - 1'b1]);

    p_irq0_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctx0_irq == (ctx0_vec != '0));

    p_irq1_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctx1_irq == (ctx1_vec != '0));

    p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx0_vec <= VEC_W'(NUM_SRC)) && (ctx1_vec <= VEC_W'(NUM_SRC)));

    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unused |=> (rsp_rdata == '0));

    p_upper_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> (rsp_rdata[31:HI_W] == '0));

endmodule

bind shmic_top shmic_checker #(
    .NUM_SRC    (NUM_SRC),
    .VEC_W      (VEC_W),
    .SHADOW_SET (SHADOW_SET),
    .PERCPU_SET (PERCPU_SET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ctx0_irq  (ctx0_irq),
    .ctx0_vec  (ctx0_vec),
    .ctx1_irq  (ctx1_irq),
    .ctx1_vec  (ctx1_vec)
);

// File: tb/tb_shmic_top.sv
`timescale 1ns/1ps
module tb_shmic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] src_lines = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_bmask = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        ctx0_irq, ctx1_irq;
    logic [5:0]  ctx0_vec, ctx1_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shmic_top dut (
        .clk (clk), .rst_n (rst_n), .src_lines (src_lines),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_bmask (req_bmask),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .ctx0_irq (ctx0_irq), .ctx0_vec (ctx0_vec),
        .ctx1_irq (ctx1_irq), .ctx1_vec (ctx1_vec)
    );

    // ---------------- configuration seen by the model ----------------
    int          pair_tgt [2] = '{30, 35};
    int          pair_shd [2] = '{29, 12};
    bit [39:0]   route1 = 40'h40_0F00_0000;

    function automatic int shadow_for(int src);
        for (int p = 0; p < 2; p++) if (pair_tgt[p] == src) return pair_shd[p];
        return -1;
    endfunction

    function automatic bit used_as_shadow(int src);
        for (int p = 0; p < 2; p++) if (pair_shd[p] == src) return 1'b1;
        return 1'b0;
    endfunction

    // ---------------- behavioural reference ----------------
    bit [39:0] m_en;
    int        m_vec0, m_vec1;
    bit        m_rv;
    bit [31:0] m_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = '0; m_vec0 = 0; m_vec1 = 0; m_rv = 0; m_rd = '0;
        end else begin
            bit [39:0] pend;
            int v0, v1;
            v0 = 0; v1 = 0; pend = '0;
            for (int i = 0; i < 40; i++) begin
                if (src_lines[i] && !used_as_shadow(i)) begin
                    int s;
                    pend[i] = 1'b1;
                    s = shadow_for(i);
                    if (s >= 0) begin
                        if (m_en[i]) v0 = i + 1;
                        if (m_en[s]) v1 = i + 1;
                    end else if (route1[i]) begin
                        if (m_en[i]) v1 = i + 1;
                    end else begin
                        if (m_en[i]) v0 = i + 1;
                    end
                end
            end
            m_vec0 = v0;
            m_vec1 = v1;
            m_rv = req_valid;
            m_rd = '0;
            if (req_valid && !req_write) begin
                if (req_addr == 8'h04) m_rd = m_en[31:0];
                else if (req_addr == 8'h50) m_rd = {24'h0, m_en[39:32]};
                else if (req_addr == 8'h08) m_rd = pend[31:0];
                else if (req_addr == 8'h54) m_rd = {24'h0, pend[39:32]};
            end
            if (req_valid && req_write) begin
                if (req_addr == 8'h04)
                    m_en[31:0] = (m_en[31:0] & ~req_bmask) | (req_wdata & req_bmask);
                else if (req_addr == 8'h50)
                    m_en[39:32] = (m_en[39:32] & ~req_bmask[7:0]) | (req_wdata[7:0] & req_bmask[7:0]);
            end
        end
    end

    task automatic check(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", what, act, exp);
        end
    endtask

    // per-clock comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(ctx0_vec == 6'(m_vec0), "R8 context 0 vector vs model", ctx0_vec, m_vec0);
            check(ctx1_vec == 6'(m_vec1), "R8 context 1 vector vs model", ctx1_vec, m_vec1);
            check(ctx0_irq == (m_vec0 != 0), "R8 context 0 request vs model", ctx0_irq, m_vec0 != 0);
            check(ctx1_irq == (m_vec1 != 0), "R8 context 1 request vs model", ctx1_irq, m_vec1 != 0);
            check(rsp_valid == m_rv, "R3 response valid vs model", rsp_valid, m_rv);
            check(rsp_rdata == m_rd, "R3 response data vs model", rsp_rdata, m_rd);
        end
    end

    // ---------------- access helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [31:0] bm);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_bmask = bm;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0; req_bmask = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic set_lines(input logic [39:0] v);
        @(negedge clk);
        src_lines = v;
        @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [39:0] ln;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1: quiet after reset
        check(ctx0_vec == 0 && ctx1_vec == 0 && !ctx0_irq && !ctx1_irq, "R1 outputs after reset",
              {ctx0_vec, ctx1_vec}, 0);
        rd(8'h04, d); check(d == 32'h0, "R1 lower enable after reset", d, 0);
        rd(8'h50, d); check(d == 32'h0, "R1 upper enable after reset", d, 0);

        // R2 / R3: full and masked writes
        wr(8'h04, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(8'h04, d); check(d == 32'hFFFF_FFFF, "R2 lower enable word", d, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0, 32'h0000_00F0);
        rd(8'h04, d); check(d == 32'hFFFF_FF0F, "R3 masked clear", d, 32'hFFFF_FF0F);
        wr(8'h04, 32'hFFFF_FF50, 32'h0000_00F0);
        rd(8'h04, d); check(d == 32'hFFFF_FF5F, "R3 masked set", d, 32'hFFFF_FF5F);

        // R9: upper word width and unused offsets
        wr(8'h50, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(8'h50, d); check(d == 32'h0000_00FF, "R9 upper enable bits 8-31", d, 32'hFF);
        wr(8'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(8'h10, d); check(d == 32'h0, "R9 unused offset reads zero", d, 0);
        rd(8'h04, d); check(d == 32'hFFFF_FF5F, "R9 unused write left enables", d, 32'hFFFF_FF5F);

        // R10: pending words are read-only
        wr(8'h08, 32'h0, 32'hFFFF_FFFF);
        wr(8'h54, 32'h0, 32'hFFFF_FFFF);
        rd(8'h04, d); check(d == 32'hFFFF_FF5F, "R10 lower enables after pending write", d, 32'hFFFF_FF5F);
        rd(8'h50, d); check(d == 32'h0000_00FF, "R10 upper enables after pending write", d, 32'hFF);

        // R4 / R6: routing of ordinary sources
        ln = '0; ln[3] = 1; ln[25] = 1;
        set_lines(ln);
        check(ctx0_vec == 4, "R6 source 3 to context 0", ctx0_vec, 4);
        check(ctx1_vec == 26, "R6 source 25 to context 1", ctx1_vec, 26);
        rd(8'h08, d); check(d == 32'h0200_0008, "R4 pending low word", d, 32'h0200_0008);

        // R4: disabled source still pending, R8: does not win
        ln[5] = 1;
        set_lines(ln);
        rd(8'h08, d); check(d == 32'h0200_0028, "R4 pending ignores enables", d, 32'h0200_0028);
        check(ctx0_vec == 4, "R8 disabled source 5 skipped", ctx0_vec, 4);

        // R5: shadow lines are invisible
        ln[29] = 1; ln[12] = 1;
        set_lines(ln);
        rd(8'h08, d); check(d == 32'h0200_0028, "R5 shadow lines not pending", d, 32'h0200_0028);
        check(ctx0_vec == 4 && ctx1_vec == 26, "R5 shadow lines raise nothing",
              {ctx0_vec, ctx1_vec}, {6'd4, 6'd26});

        // R7: per-CPU source 30, shadow 29
        ln[30] = 1;
        set_lines(ln);
        check(ctx0_vec == 31, "R7 source 30 context 0", ctx0_vec, 31);
        check(ctx1_vec == 31, "R7 source 30 context 1", ctx1_vec, 31);
        wr(8'h04, 32'h0, 32'h2000_0000);
        settle();
        check(ctx1_vec == 26, "R7 shadow bit gates context 1", ctx1_vec, 26);
        check(ctx0_vec == 31, "R7 context 0 unaffected by shadow bit", ctx0_vec, 31);
        wr(8'h04, 32'h2000_0000, 32'h6000_0000);
        settle();
        check(ctx0_vec == 4, "R7 own bit gates context 0", ctx0_vec, 4);
        check(ctx1_vec == 31, "R7 context 1 via shadow only", ctx1_vec, 31);

        // R6 / R7 / R8: upper word sources
        ln[35] = 1; ln[38] = 1;
        set_lines(ln);
        check(ctx0_vec == 36, "R7 source 35 context 0", ctx0_vec, 36);
        check(ctx1_vec == 39, "R8 highest source 38 wins context 1", ctx1_vec, 39);
        rd(8'h54, d); check(d == 32'h0000_0048, "R4 pending high word", d, 32'h48);
        wr(8'h04, 32'h0, 32'h0000_1000);
        wr(8'h50, 32'h0, 32'h0000_0040);
        settle();
        check(ctx1_vec == 31, "R7 shadow 12 cleared, context 1 falls back", ctx1_vec, 31);
        check(ctx0_vec == 36, "R7 context 0 keeps source 35", ctx0_vec, 36);

        // R1: mask-all
        wr(8'h04, 32'h0, 32'hFFFF_FFFF);
        wr(8'h50, 32'h0, 32'hFFFF_FFFF);
        settle();
        check(!ctx0_irq && !ctx1_irq && ctx0_vec == 0 && ctx1_vec == 0, "R1 quiet after mask-all",
              {ctx0_irq, ctx1_irq, ctx0_vec, ctx1_vec}, 0);
        rd(8'h08, d); check(d == 32'h4200_0028, "R4 pending after mask-all", d, 32'h4200_0028);

        // R6: lone context 1 source
        set_lines(40'h00_0100_0000);
        wr(8'h04, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        settle();
        check(ctx0_vec == 0 && !ctx0_irq, "R6 source 24 not in context 0", ctx0_vec, 0);
        check(ctx1_vec == 25 && ctx1_irq, "R6 source 24 in context 1", ctx1_vec, 25);

        settle();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule